// File: doc/BRIEF.md
# Edge-Regenerating Interrupt Expander

This block gathers eight level-sensitive interrupt sources and presents them to an edge-triggered interrupt controller as one shared request line. Every source passes through a two-flop synchronizer. A per-source enable bit gates the source before it joins the combined OR that drives the request. Software sees three views of the sources: the enable bits, the live level of the enabled sources, and a sticky record of rising edges for each source.

An edge-triggered controller misses a second cause if the shared line never drops. The block handles this through a write-one-to-clear register. A clear write erases the selected sticky bits and pulls the request line low for exactly one cycle. The line is then evaluated again, so any enabled source that is still active produces a new rising edge. The intended handler reads the edge status, services each cause, write-clears each serviced bit and then returns.

The register bus is synchronous, with a 2-bit address, a write strobe, write data and combinational read data. Address 0 holds the enable bits (1 = source enabled). Address 1 is the enabled level view. Address 2 is the sticky edge view. Address 3 is the clear register.

Top module: `irq_edge_expander`

## Requirements
- R1: After reset, all enable bits are 0 (every source masked), all sticky edge bits are 0 and `irq_o` is 0.
- R2: Each source passes through a two-flop synchronizer, and `irq_o` is a registered output. An enabled source that rises produces `irq_o` = 1 after the third rising clock edge.
- R3: `irq_o` follows the OR of the synchronized sources ANDed with the enable bits, one cycle later. It is 0 whenever no enabled source is active.
- R4: A read of address 1 returns the synchronized sources ANDed with the enable bits.
- R5: A read of address 2 returns the sticky edge bits. Bit i is set by a rising edge of synchronized source i, whatever the enable bits hold, and stays set until it is cleared.
- R6: A write to address 3 clears every sticky bit whose write-data bit is 1. A rising edge of the same source in the same cycle wins, and the bit stays set.
- R7: A write to address 3 with nonzero data forces `irq_o` to 0 for exactly one cycle. In the next cycle `irq_o` is evaluated again, so an enabled source that is still active gives a new rising edge.
- R8: A write of all zeros to address 3 has no effect on the sticky bits or on `irq_o`.
- R9: A write to address 0 replaces the enable bits. `irq_o` reflects the new enables one cycle later, and the sticky edge bits are left unchanged.
- R10: A read of address 3 returns 0. Writes to addresses 1 and 2 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N (8) | Level-sensitive interrupt sources, asynchronous |
| bus_addr | input | 2 | Register address: 0 enable, 1 level, 2 edge, 3 clear |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | N (8) | Write data |
| bus_rdata | output | N (8) | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt request to the edge-triggered controller |

## Verification
The bench targets the re-arm pulse. A clear write while a source stays active must produce a 1-0-1 sequence on `irq_o`. A design that skips the low cycle leaves the controller blind to the next cause, and one that holds the line low too long delays the new edge. It also checks that a zero clear write changes nothing and that masking keeps the sticky bits. A design that pulses the line on any clear access, or that ANDs the edge bits with the enables, would fail those checks. Random traffic also lands rising edges in the same cycle as clears of the same bit, where the edge must win.

// File: rtl/irq_edge_expander.sv
module irq_edge_expander #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [N-1:0] bus_wdata,
  output logic [N-1:0] bus_rdata,
  output logic         irq_o
);
  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_LVL  = 2'd1;
  localparam logic [1:0] A_EDGE = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  logic [N-1:0] sync1, sync2, sync3;
  logic [N-1:0] en_q, edge_q;
  logic         irq_q;

  wire en_wr  = bus_we && (bus_addr == A_EN);
  wire clr_wr = bus_we && (bus_addr == A_CLR);
  wire clr_hit = clr_wr && (|bus_wdata);
  wire [N-1:0] clr_bits = clr_wr ? bus_wdata : '0;
  wire [N-1:0] rise = sync2 & ~sync3;
  wire [N-1:0] lvl  = sync2 & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= bus_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) edge_q[i] <= 1'b0;
      else if (rise[i]) edge_q[i] <= 1'b1;
      else if (clr_bits[i]) edge_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= !clr_hit && (|lvl);
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_LVL:   bus_rdata = lvl;
      A_EDGE:  bus_rdata = edge_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_edge_expander_chk.sv
module irq_edge_expander_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [N-1:0] bus_wdata,
  input logic         irq_o,
  input logic [N-1:0] lvl,
  input logic [N-1:0] rise,
  input logic [N-1:0] edge_q
);
  wire clr_acc  = bus_we && (bus_addr == 2'd3);
  wire clr_nz   = clr_acc && (|bus_wdata);
  wire en_acc   = bus_we && (bus_addr == 2'd0);

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_nz |=> !irq_o);

  a_r7_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_nz && (|lvl)) |=> irq_o);

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> !irq_o);

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> ((edge_q & $past(bus_wdata & ~rise)) == '0));

  a_r8_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc && bus_wdata == '0) |=> (edge_q == ($past(edge_q) | $past(rise))));

  a_r9_mask_keeps_edges: assert property (@(posedge clk) disable iff (!rst_n)
    en_acc |=> ((edge_q & $past(edge_q)) == $past(edge_q)));
endmodule

bind irq_edge_expander irq_edge_expander_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .lvl(lvl), .rise(rise),
  .edge_q(edge_q)
);

// File: tb/sim_irq_edge_expander.sv
`timescale 1ns/1ps
module sim_irq_edge_expander;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [1:0] addr = '0;
  logic we = 1'b0;
  logic [N-1:0] wd = '0;
  logic [N-1:0] rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_edge_expander #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_edge;
  logic m_irq;

  function automatic logic [N-1:0] next_edge(input logic [N-1:0] e, input logic [N-1:0] s2,
                                             input logic [N-1:0] s3, input logic cw,
                                             input logic [N-1:0] d);
    logic [N-1:0] c;
    c = cw ? d : '0;
    return (e & ~c) | (s2 & ~s3);
  endfunction

  function automatic logic [N-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return m_s2 & m_en;
      2'd2: return m_edge;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_en <= '0; m_edge <= '0; m_irq <= 1'b0;
    end else begin
      m_s1 <= src; m_s2 <= m_s1; m_s3 <= m_s2;
      if (we && addr == 2'd0) m_en <= wd;
      m_edge <= next_edge(m_edge, m_s2, m_s3, we && addr == 2'd3, wd);
      m_irq <= !(we && addr == 2'd3 && wd != '0) && ((m_s2 & m_en) != '0);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] s, input logic w, input logic [1:0] a,
                     input logic [N-1:0] d);
    src = s; we = w; addr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
    chk("model irq R3 R7", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    chk("model read R4 R5 R10", rdata, exp_read(a));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 2'd0; #1;
    chk("R1 enable reset", rdata, 8'h00);
    addr = 2'd2; #1;
    chk("R1 edge reset", rdata, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    cyc(8'h00, 1'b1, 2'd0, 8'hFF);
    cyc(8'h04, 1'b0, 2'd1, 8'h00);
    chk("R2 irq after one edge", {7'd0, irq}, 8'h00);
    cyc(8'h04, 1'b0, 2'd1, 8'h00);
    chk("R4 level read", rdata, 8'h04);
    chk("R2 irq after two edges", {7'd0, irq}, 8'h00);
    cyc(8'h04, 1'b0, 2'd2, 8'h00);
    chk("R2 irq after three edges", {7'd0, irq}, 8'h01);
    chk("R5 edge latched", rdata, 8'h04);
    cyc(8'h04, 1'b1, 2'd3, 8'h04);
    chk("R7 clear pulls irq low", {7'd0, irq}, 8'h00);
    cyc(8'h04, 1'b0, 2'd2, 8'h00);
    chk("R7 irq rises again", {7'd0, irq}, 8'h01);
    chk("R6 edge cleared", rdata, 8'h00);
    cyc(8'h04, 1'b1, 2'd3, 8'h00);
    chk("R8 zero clear keeps irq", {7'd0, irq}, 8'h01);
    cyc(8'h24, 1'b0, 2'd2, 8'h00);
    cyc(8'h24, 1'b0, 2'd2, 8'h00);
    cyc(8'h24, 1'b0, 2'd2, 8'h00);
    chk("R5 second edge latched", rdata, 8'h20);
    cyc(8'h24, 1'b1, 2'd3, 8'h00);
    chk("R8 zero clear keeps edge", rdata, 8'h00);
    cyc(8'h24, 1'b0, 2'd2, 8'h00);
    chk("R8 edge intact after zero clear", rdata, 8'h20);
    cyc(8'h24, 1'b1, 2'd0, 8'h00);
    chk("R9 irq one cycle after mask", {7'd0, irq}, 8'h01);
    cyc(8'h24, 1'b0, 2'd2, 8'h00);
    chk("R9 irq dropped", {7'd0, irq}, 8'h00);
    chk("R9 edge kept", rdata, 8'h20);
    cyc(8'h25, 1'b0, 2'd2, 8'h00);
    cyc(8'h25, 1'b0, 2'd2, 8'h00);
    cyc(8'h25, 1'b0, 2'd2, 8'h00);
    chk("R5 masked source latched", rdata, 8'h21);
    chk("R3 masked source no irq", {7'd0, irq}, 8'h00);
    cyc(8'h25, 1'b1, 2'd1, 8'hFF);
    cyc(8'h25, 1'b1, 2'd2, 8'h00);
    cyc(8'h25, 1'b0, 2'd2, 8'h00);
    chk("R10 write to edge ignored", rdata, 8'h21);
    cyc(8'h25, 1'b0, 2'd0, 8'h00);
    chk("R10 write to level ignored", rdata, 8'h00);
    cyc(8'h25, 1'b0, 2'd3, 8'h00);
    chk("R10 clear reads zero", rdata, 8'h00);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s;
      logic [1:0] a;
      logic w;
      logic [N-1:0] d;
      s = src;
      if ($urandom_range(0, 7) == 0) s = s ^ (8'h1 << $urandom_range(0, N - 1));
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d = '0;
      cyc(s, w, a, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule